// File: doc/BRIEF.md
# Round-Robin Multi-Lane Output Queue

This block is the output queue of a single switch port. In one clock it can take up to `LANES` cells, and it sends them toward the link one at a time. It never uses a memory that needs more than one write and one read per cycle.

Arriving cells pass through a rotating lane shifter that drives a bank of `LANES` small FIFOs. A persistent write offset makes consecutive cells land in consecutive FIFOs, wrapping at the end of the bank. A read pointer visits the FIFOs in the same rotating order and takes one cell per handshake. The bank therefore behaves as one logical FIFO of `LANES*DEPTH` cells that keeps arrival order.

If a burst finds too little room, the cells that do not fit are discarded. A wrapping counter records how many cells were dropped.

Top module: `rrob_out_buf`

## Requirements
- R1: After reset is released, `valid_o` is low and `ovf_cnt_o` is zero.
- R2: Cells leave in arrival order. Within one cycle, lane 0 is the earliest arrival and higher lanes follow in index order.
- R3: `valid_o` is high exactly when at least one accepted cell has not yet been delivered.
- R4: A cell is delivered on a rising clock edge where both `valid_o` and `ready_i` are high. While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `data_o` holds its value on the next cycle.
- R5: All arrivals of one cycle, up to `LANES` cells, are accepted in that cycle as long as enough space is free. Total capacity is `LANES*DEPTH` cells. Free space is measured before that same cycle's departure, so a departure frees space only from the next cycle on.
- R6: When a cycle brings more cells than there is free space, the lowest-numbered lanes are accepted first. Each remaining cell is dropped and adds one to `ovf_cnt_o`, which wraps at `2**CNT_W`.
- R7: A cell accepted on one clock edge can be presented on `data_o` from the following cycle on. Arrivals and departures go on in the same cycle without loss of rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | LANES | Lane valid bits. Valid lanes are packed from lane 0 upward. |
| data_i | input | LANES*DATA_W | Lane data. Lane i is in bits [i*DATA_W +: DATA_W]. |
| ready_i | input | 1 | Link accepts a cell this cycle |
| valid_o | output | 1 | A cell is presented |
| data_o | output | DATA_W | Cell at the head of the logical queue |
| ovf_cnt_o | output | CNT_W | Wrapping count of dropped cells |

## Verification
The assertions assume that the set of valid lanes is always packed: a run of ones starting at lane 0, with no gaps. The occupancy tracker in the checker relies on this to predict how many cells each cycle accepts and drops. The bench only ever drives `valid_i` as `(1<<k)-1`, with `k` chosen from 0 to `LANES`. Stimulus mixes free-running reads, long stalls under full-width bursts that force overflow, a full drain, and single-lane trickle traffic.

// File: rtl/rrob_pkg.sv
package rrob_pkg;
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction
endpackage

// File: rtl/rrob_fifo.sv
module rrob_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rrob_shifter.sv
module rrob_shifter #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [LANES-1:0]        vld_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]        amt_i,
  output logic [LANES-1:0]        vld_o,
  output logic [LANES*DATA_W-1:0] data_o
);
  // output j takes lane (j - amt) mod LANES
  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [IDX_W-1:0] src;
    assign src = IDX_W'(rrob_pkg::ring_add(j, LANES - int'(amt_i), LANES));
    assign vld_o[j] = vld_i[src];
    assign data_o[j*DATA_W +: DATA_W] = data_i[int'(src)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rrob_out_buf.sv
module rrob_out_buf #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        valid_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic                    ready_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       data_o,
  output logic [CNT_W-1:0]        ovf_cnt_o
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0]        wr_off_q, rd_ptr_q;
  logic [CNT_W-1:0]        ovf_q;
  logic [LANES-1:0]        acc, buf_push, buf_full, buf_empty, pop_vec;
  logic [LANES*DATA_W-1:0] buf_wdata, buf_rdata;
  int unsigned             n_acc, n_vld;
  logic                    pop;

  // accept a packed prefix of lanes whose target buffers have room
  always_comb begin
    logic        run;
    int unsigned tgt;
    run = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      tgt    = rrob_pkg::ring_add(wr_off_q, i, LANES);
      run    = run & valid_i[i] & ~buf_full[tgt];
      acc[i] = run;
    end
    n_acc = $countones(acc);
    n_vld = $countones(valid_i);
  end

  rrob_shifter #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_shifter (
    .vld_i (acc),
    .data_i(data_i),
    .amt_i (wr_off_q),
    .vld_o (buf_push),
    .data_o(buf_wdata)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_buf
    rrob_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (buf_push[j]),
      .data_i (buf_wdata[j*DATA_W +: DATA_W]),
      .pop_i  (pop_vec[j]),
      .data_o (buf_rdata[j*DATA_W +: DATA_W]),
      .empty_o(buf_empty[j]),
      .full_o (buf_full[j])
    );
  end

  assign valid_o = ~buf_empty[rd_ptr_q];
  assign data_o  = buf_rdata[int'(rd_ptr_q)*DATA_W +: DATA_W];
  assign pop     = valid_o & ready_i;
  assign pop_vec = LANES'(pop) << rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_off_q <= '0;
      rd_ptr_q <= '0;
      ovf_q    <= '0;
    end else begin
      wr_off_q <= IDX_W'(rrob_pkg::ring_add(wr_off_q, n_acc, LANES));
      if (pop) rd_ptr_q <= IDX_W'(rrob_pkg::ring_add(rd_ptr_q, 1, LANES));
      ovf_q <= ovf_q + CNT_W'(n_vld - n_acc);
    end
  end

  assign ovf_cnt_o = ovf_q;
endmodule

// File: rtl/rrob_out_buf_chk.sv
module rrob_out_buf_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LANES-1:0]  valid_i,
  input logic              ready_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [CNT_W-1:0]  ovf_cnt_o
);
  localparam int CAP   = LANES * DEPTH;
  localparam int OCC_W = $clog2(CAP + 1);

  logic [OCC_W-1:0] occ_q;
  logic [CNT_W-1:0] ovf_ref_q;
  int unsigned      k, free, acc_n, drop;

  always_comb begin
    k     = $countones(valid_i);
    free  = CAP - int'(occ_q);
    acc_n = (k < free) ? k : free;
    drop  = k - acc_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      ovf_ref_q <= '0;
    end else begin
      occ_q     <= OCC_W'(int'(occ_q) + acc_n - ((valid_o && ready_i) ? 1 : 0));
      ovf_ref_q <= ovf_ref_q + CNT_W'(drop);
    end
  end

  a_r1_reset_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && ovf_cnt_o == '0));

  // input contract: valid lanes packed from lane 0
  a_r2_lanes_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i & (valid_i + 1'b1)) == '0);

  a_r3_valid_tracks_occ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (occ_q != '0));

  a_r4_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  a_r5_no_drop_with_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k <= free) |=> $stable(ovf_cnt_o));

  a_r6_drop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_cnt_o == ovf_ref_q);
endmodule

bind rrob_out_buf rrob_out_buf_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ready_i  (ready_i),
  .valid_o  (valid_o),
  .data_o   (data_o),
  .ovf_cnt_o(ovf_cnt_o)
);

// File: tb/test_rrob_out_buf.sv
module test_rrob_out_buf;
  localparam int L   = 4;
  localparam int W   = 8;
  localparam int D   = 16;
  localparam int C   = 16;
  localparam int CAP = L * D;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [L-1:0]   valid_i = '0;
  logic [L*W-1:0] data_i = '0;
  logic           ready_i = 1'b0;
  logic           valid_o;
  logic [W-1:0]   data_o;
  logic [C-1:0]   ovf_cnt_o;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] q[$];
  int unsigned  m_ovf = 0;
  int unsigned  seq = 0;

  always #5 clk = ~clk;

  rrob_out_buf #(.LANES(L), .DATA_W(W), .DEPTH(D), .CNT_W(C)) i_rrob_out_buf (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .ready_i(ready_i), .valid_o(valid_o), .data_o(data_o), .ovf_cnt_o(ovf_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare outputs with model, then drive and advance model
  task automatic cycle(input int k, input bit rdy);
    int unsigned occ, acc;
    @(negedge clk);
    chk(valid_o == (q.size() != 0), "R3 R7 valid", valid_o, q.size() != 0);
    if (q.size() != 0 && valid_o) chk(data_o == q[0], "R2 R4 order", data_o, q[0]);
    chk(ovf_cnt_o == C'(m_ovf), "R5 R6 drops", ovf_cnt_o, C'(m_ovf));
    valid_i = L'((1 << k) - 1);
    for (int i = 0; i < L; i++) data_i[i*W +: W] = W'(seq + i);
    ready_i = rdy;
    occ = q.size();
    if (rdy && occ > 0) void'(q.pop_front());
    acc = (k < CAP - occ) ? k : CAP - occ;
    for (int i = 0; i < int'(acc); i++) q.push_back(W'(seq + i));
    m_ovf += k - acc;
    seq += k;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(ovf_cnt_o == '0, "R1 ovf", ovf_cnt_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid after release", valid_o, 0);
    chk(ovf_cnt_o == '0, "R1 ovf after release", ovf_cnt_o, 0);
    // R5: full-width burst into empty queue, stalled output
    cycle(L, 1'b0);
    cycle(0, 1'b0);
    chk(valid_o == 1'b1, "R5 burst visible", valid_o, 1);
    // mixed traffic, random stalls
    for (int n = 0; n < 600; n++) cycle($urandom_range(0, L), $urandom_range(0, 1) == 1);
    // heavy stalls with full bursts force overflow (R6)
    for (int n = 0; n < 300; n++) cycle(L, $urandom_range(0, 9) == 0);
    chk(m_ovf > 0, "R6 overflow reached", m_ovf, 1);
    // drain
    for (int n = 0; n < CAP + 10; n++) cycle(0, 1'b1);
    // full rate in and out (R7)
    for (int n = 0; n < 400; n++) cycle($urandom_range(0, L), 1'b1);
    // single-lane trickle
    for (int n = 0; n < 300; n++) cycle($urandom_range(0, 1), $urandom_range(0, 2) != 0);
    for (int n = 0; n < CAP + 10; n++) cycle(0, 1'b1);
    cycle(0, 1'b1);
    chk(q.size() == 0 && valid_o == 1'b0, "R3 empty at end", valid_o, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule